// File: doc/BRIEF.md
# Limit-Register Interval Timer

This block is an up-counting interval timer for a processor subsystem. A prescaler divides the system clock into a periodic step, normally one per microsecond. On each step the count advances by one. When the count would reach the programmed limit, it reloads to 1, not 0. At the same time it sets a sticky flag that drives a level-sensitive interrupt request. Because of the reload to 1, a period of N steps needs a limit of N+1.

Software reaches the timer through a word-wide register strobe interface. The register addresses are word indices on `reg_addr`:

| Index | Register |
|-------|----------|
| 0 | Limit. Writing it restarts the count. Reading it clears the flag. |
| 1 | Count. Read-only. |
| 2 | Limit alias. Writing it replaces the limit and keeps the count running. |
| 3 | User-mode bit. |
| 4 | Run bit. |

Limit and count words share one layout. Bit 31 is the flag. The count field sits just below it, and the bits under the field read as zero.

The parameter `HALF_US_STEP` moves to a 22-bit field whose lowest bit is bit 9, for a 500 ns step. `CLK_PER_TICK` sets the number of clocks per step.

Top module: `lit_interval_timer`

## Requirements
- R1: After reset the count reads 1. The limit, the flag, the user-mode bit, the run bit and `irq` are all 0.
- R2: The first step occurs on the CLK_PER_TICK-th rising edge after reset release, and a step follows every CLK_PER_TICK edges after that. Each enabled step adds one to the count field, which sits in bits 30:10 (default layout).
- R3: When count+1 reaches or passes the effective limit, the step reloads the count to 1 and sets the flag in bit 31. With a limit of 4 the count reads 1, 2, 3, 1. `irq` is high exactly while the flag is set.
- R4: A read of index 0 returns {flag, limit, zeros} and clears the flag and `irq`. A wrap on the same edge keeps the flag set. Reads of index 1 or 2 leave the flag unchanged.
- R5: A write to index 0 loads the limit from write bits 30:10, sets the count to 1 and clears the flag.
- R6: A write to index 2 loads the limit and leaves the count and the flag untouched. If the new limit is at or below count+1, the next step wraps.
- R7: A limit field of 0 or 1 acts as the all-ones field value, so the count keeps climbing instead of sticking at 1.
- R8: Bit 0 of index 3 selects user mode and bit 0 of index 4 is the run bit. In user mode the count holds while run is 0. Outside user mode it always counts.
- R9: Writes to index 1 have no effect. Bit 31 and bits 9:0 of a limit write are ignored. Read data appears on the cycle after the read strobe, with bits 9:0 of the limit and count words at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_addr | input | 3 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Level interrupt request, high while the flag is set |

## Verification
The assertions assume that read and write strobes are never raised together and that each strobe names one index. They also assume the host never writes both limit indices at once, so a restart and a keep-count load cannot coincide. The stimulus drives only one access per cycle, always between clock edges, and leaves idle gaps of varied length. Reads therefore land at many step phases, including edges where a wrap and a flag-clearing read coincide.

// File: rtl/lit_pkg.sv
package lit_pkg;

   typedef enum logic [2:0] {
      SEL_LIMIT      = 3'd0,
      SEL_COUNT      = 3'd1,
      SEL_LIMIT_KEEP = 3'd2,
      SEL_USER       = 3'd3,
      SEL_RUN        = 3'd4
   } reg_sel_e;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned FLAG_BIT = 31;

   function automatic int unsigned field_width(input bit half_step);
      return half_step ? 22 : 21;
   endfunction

endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler #(
   parameter int unsigned DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   initial begin
      assert (DIV >= 1) else $error("lit_prescaler: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_pass
         assign tick = rst_n;
      end else begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase;

         always_ff @(posedge clk) begin
            if (!rst_n)             phase <= '0;
            else if (phase == LAST) phase <= '0;
            else                    phase <= phase + 1'b1;
         end

         assign tick = (phase == LAST);

         // R2: steps are spaced, never back to back
         p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/lit_count_core.sv
module lit_count_core #(
   parameter int unsigned CNT_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_ok,
   input  logic             wr_restart,
   input  logic             wr_keep,
   input  logic [CNT_W-1:0] lim_in,
   input  logic             rd_clear,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] lim,
   output logic             flag
);

   localparam logic [CNT_W-1:0] FULL = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 31) else $error("lit_count_core: CNT_W out of range");
   end

   logic [CNT_W-1:0] eff_lim;
   logic [CNT_W:0]   nxt;
   logic             step;
   logic             wrap;

   assign eff_lim = (lim <= ONE) ? FULL : lim;
   assign nxt     = {1'b0, cnt} + 1'b1;
   assign step    = tick && run_ok;
   assign wrap    = step && (nxt >= {1'b0, eff_lim});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim <= '0;
      end else if (wr_restart || wr_keep) begin
         lim <= lim_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= ONE;
         flag <= 1'b0;
      end else if (wr_restart) begin
         cnt  <= ONE;
         flag <= 1'b0;
      end else begin
         if (step)          cnt  <= wrap ? ONE : nxt[CNT_W-1:0];
         if (wrap)          flag <= 1'b1;
         else if (rd_clear) flag <= 1'b0;
      end
   end

   // R3: the count never holds zero
   p_count_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0);

   // R3: the flag only rises after an enabled step
   p_flag_after_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(tick && run_ok));

   // R4: a limit read with no competing step clears the flag
   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && !(tick && run_ok) && !wr_restart) |=> !flag);

   // R5: a restarting write leaves count 1 and flag clear
   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_restart |=> (cnt == ONE && !flag));

   // R6: a keep-count write without a step leaves the count alone
   p_keep_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_keep && !tick) |=> $stable(cnt));

   // R8: a gated counter holds its value
   p_gated_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_ok && !wr_restart) |=> $stable(cnt));

endmodule

// File: rtl/lit_regs.sv
module lit_regs
   import lit_pkg::*;
#(
   parameter int unsigned CNT_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  lim,
   input  logic              flag,
   output logic              wr_restart,
   output logic              wr_keep,
   output logic [CNT_W-1:0]  lim_in,
   output logic              rd_clear,
   output logic              run_ok,
   output logic [WORD_W-1:0] reg_rdata
);

   localparam int unsigned LSB = FLAG_BIT - CNT_W;

   logic user_q;
   logic run_q;
   logic unused_wbits;

   assign unused_wbits = ^{reg_wdata[FLAG_BIT], reg_wdata[LSB-1:1]};

   assign wr_restart = reg_wr && (reg_addr == SEL_LIMIT);
   assign wr_keep    = reg_wr && (reg_addr == SEL_LIMIT_KEEP);
   assign rd_clear   = reg_rd && (reg_addr == SEL_LIMIT);
   assign lim_in     = reg_wdata[FLAG_BIT-1 -: CNT_W];
   assign run_ok     = !user_q || run_q;

   function automatic logic [WORD_W-1:0] pack_word(input logic f, input logic [CNT_W-1:0] v);
      return {f, v, {LSB{1'b0}}};
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         user_q <= 1'b0;
         run_q  <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == SEL_USER) user_q <= reg_wdata[0];
         if (reg_addr == SEL_RUN)  run_q  <= reg_wdata[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         case (reg_addr)
            SEL_LIMIT, SEL_LIMIT_KEEP: reg_rdata <= pack_word(flag, lim);
            SEL_COUNT:                 reg_rdata <= pack_word(flag, cnt);
            SEL_USER:                  reg_rdata <= {{(WORD_W-1){1'b0}}, user_q};
            SEL_RUN:                   reg_rdata <= {{(WORD_W-1){1'b0}}, run_q};
            default:                   reg_rdata <= '0;
         endcase
      end
   end

   // R9: a write to the count index leaves mode bits untouched
   p_count_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == SEL_COUNT) |=> ($stable(user_q) && $stable(run_q)));

endmodule

// File: rtl/lit_interval_timer.sv
module lit_interval_timer
   import lit_pkg::*;
#(
   parameter int unsigned CLK_PER_TICK = 50,
   parameter bit          HALF_US_STEP = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq
);

   localparam int unsigned CNT_W = field_width(HALF_US_STEP);

   logic             tick;
   logic             run_ok;
   logic             wr_restart;
   logic             wr_keep;
   logic             rd_clear;
   logic [CNT_W-1:0] lim_in;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             flag;

   lit_prescaler #(.DIV(CLK_PER_TICK)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   lit_count_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run_ok     (run_ok),
      .wr_restart (wr_restart),
      .wr_keep    (wr_keep),
      .lim_in     (lim_in),
      .rd_clear   (rd_clear),
      .cnt        (cnt),
      .lim        (lim),
      .flag       (flag)
   );

   lit_regs #(.CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .cnt        (cnt),
      .lim        (lim),
      .flag       (flag),
      .wr_restart (wr_restart),
      .wr_keep    (wr_keep),
      .lim_in     (lim_in),
      .rd_clear   (rd_clear),
      .run_ok     (run_ok),
      .reg_rdata  (reg_rdata)
   );

   assign irq = flag;

   // R4: a read of the flag-clearing index without a step drops irq
   p_irq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd0 && !tick && !reg_wr) |=> !irq);

endmodule

// File: tb/lit_interval_timer_bench.sv
module lit_interval_timer_bench;

   localparam int DIV  = 4;
   localparam int MAXV = (1 << 21) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int vectors = 0;
   int miscompares = 0;

   always #10 clk = ~clk;

   lit_interval_timer #(.CLK_PER_TICK(DIV), .HALF_US_STEP(1'b0)) u_lit_interval_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   // reference model built from the requirements
   int    m_p, m_cnt, m_lim, m_flag, m_user, m_run;
   int    t_eff, t_nxt;
   bit    t_tick, t_step, t_wrap;
   string cur_tag = "R1";
   logic [31:0] q_exp[$];
   string       q_tag[$];
   bit          rd_pending = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_p = 0; m_cnt = 1; m_lim = 0; m_flag = 0; m_user = 0; m_run = 0;
         rd_pending <= 1'b0;
      end else begin
         if (reg_rd) begin
            case (reg_addr)
               3'd0, 3'd2: q_exp.push_back({m_flag[0], m_lim[20:0], 10'b0});
               3'd1:       q_exp.push_back({m_flag[0], m_cnt[20:0], 10'b0});
               3'd3:       q_exp.push_back({31'b0, m_user[0]});
               3'd4:       q_exp.push_back({31'b0, m_run[0]});
               default:    q_exp.push_back(32'b0);
            endcase
            q_tag.push_back(cur_tag);
         end
         rd_pending <= reg_rd;
         t_tick = (m_p == DIV - 1);
         m_p    = t_tick ? 0 : m_p + 1;
         t_step = t_tick && (m_user == 0 || m_run == 1);
         t_eff  = (m_lim <= 1) ? MAXV : m_lim;
         t_nxt  = m_cnt + 1;
         t_wrap = t_step && (t_nxt >= t_eff);
         if (reg_wr && reg_addr == 3'd0) begin
            m_cnt = 1; m_flag = 0;
         end else begin
            if (t_step) m_cnt = t_wrap ? 1 : t_nxt;
            if (t_wrap) m_flag = 1;
            else if (reg_rd && reg_addr == 3'd0) m_flag = 0;
         end
         if (reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd2)) m_lim = int'(reg_wdata[30:10]);
         if (reg_wr && reg_addr == 3'd3) m_user = int'(reg_wdata[0]);
         if (reg_wr && reg_addr == 3'd4) m_run = int'(reg_wdata[0]);
      end
   end

   // monitor: compares read data one cycle after each read strobe
   always @(negedge clk) begin
      if (rd_pending && q_exp.size() > 0) begin
         logic [31:0] e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         vectors++;
         if (reg_rdata !== e) begin
            miscompares++;
            $display("FAIL %s: reg_rdata actual %h expected %h", t, reg_rdata, e);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic do_read(input logic [2:0] a, input string tag);
      @(negedge clk);
      cur_tag = tag;
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chk_irq(input string tag);
      vectors++;
      if (irq !== m_flag[0]) begin
         miscompares++;
         $display("FAIL %s: irq actual %b expected %b", tag, irq, m_flag[0]);
      end
   endtask

   task automatic finish_run();
      idle(3);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog R1..: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk_irq("R1");
      do_read(3'd1, "R1");
      do_read(3'd0, "R1");
      do_read(3'd3, "R1");
      do_read(3'd4, "R1");
      // R2: free counting with reset limit, step spacing
      for (int i = 0; i < 6; i++) begin
         do_read(3'd1, "R2");
         idle(i + 1);
      end
      // R3, R5: limit 4 gives 1,2,3,1
      do_write(3'd0, 32'd4 << 10);
      do_read(3'd1, "R5");
      for (int i = 0; i < 12; i++) begin
         do_read(3'd1, "R3");
         chk_irq("R3");
         idle(2);
      end
      // R4: count reads keep the flag, limit read clears it
      do_read(3'd1, "R4");
      do_read(3'd2, "R4");
      chk_irq("R4");
      do_read(3'd0, "R4");
      chk_irq("R4");
      do_read(3'd1, "R4");
      for (int i = 0; i < 8; i++) begin
         do_read(3'd0, "R4");
         chk_irq("R4");
         idle(i % 3);
      end
      // R9: count index is read-only, stray limit bits ignored
      do_write(3'd1, 32'hFFFF_FFFF);
      do_read(3'd1, "R9");
      do_write(3'd0, 32'h8000_03FF | (32'd50 << 10));
      do_read(3'd0, "R9");
      do_read(3'd1, "R9");
      // R6: keep-count limit update
      do_write(3'd0, 32'd100 << 10);
      idle(40);
      do_read(3'd1, "R6");
      do_write(3'd2, 32'd200 << 10);
      do_read(3'd1, "R6");
      do_read(3'd2, "R6");
      idle(30);
      do_write(3'd2, 32'd3 << 10);
      do_read(3'd1, "R6");
      idle(6);
      do_read(3'd1, "R6");
      chk_irq("R6");
      do_read(3'd0, "R6");
      // R7: limit 1 and 0 do not stick
      do_write(3'd0, 32'd1 << 10);
      idle(30);
      do_read(3'd1, "R7");
      chk_irq("R7");
      do_write(3'd0, 32'd0);
      idle(45);
      do_read(3'd1, "R7");
      chk_irq("R7");
      // R8: user mode gating
      do_write(3'd0, 32'd20 << 10);
      do_write(3'd3, 32'd1);
      do_read(3'd3, "R8");
      do_read(3'd1, "R8");
      idle(25);
      do_read(3'd1, "R8");
      do_write(3'd4, 32'd1);
      do_read(3'd4, "R8");
      idle(25);
      do_read(3'd1, "R8");
      do_write(3'd4, 32'd0);
      idle(17);
      do_read(3'd1, "R8");
      do_write(3'd3, 32'd0);
      idle(13);
      do_read(3'd1, "R8");
      finish_run();
   end

endmodule